// File: doc/BRIEF.md
# Start-Stop Interval Timer

This block measures a time interval by counting reference ticks while an internal gate is open. The tick is expected at 1 MHz, so the count is read directly in microseconds. One input edge opens the gate and another closes it. The gate behaves as a set-reset latch. When the open and close events arrive in the same cycle, the close event wins.

Three ways of defining the interval can be chosen:
- **Two-channel:** a rising edge on the start channel opens the gate, and a rising edge on the stop channel closes it.
- **Pulse width:** the rising and falling edges of the start channel open and close the gate.
- **Period:** a toggle on the start channel's rising edges keeps the gate open for exactly one input cycle.

Software arms the timer with a one-cycle pulse. The block then reports one result, with a done flag and an overflow flag, and holds that result until it is armed again.

Top module: `interval_timer`

## Requirements
- R1: After reset, `count_us` is 0, `done` is 0 and `overflow` is 0, and the timer is idle.
- R2: An `arm` pulse clears the count and both flags. The timer then waits, and no tick is counted until the gate-opening event occurs.
- R3: With `mode` = 2'b00, a rising edge on `start_in` opens the gate and a rising edge on `stop_in` closes it. The result counts the tick-qualified clock edges after the opening edge, up to and including the closing edge. `done` rises on the closing edge.
- R4: With `mode` = 2'b01, the rising edge of `start_in` opens the gate and its falling edge closes it. `stop_in` has no effect.
- R5: With `mode` = 2'b10, the first rising edge of `start_in` opens the gate and the next rising edge closes it. Falling edges and `stop_in` have no effect.
- R6: In `mode` 2'b00, if the opening and closing edges arrive in the same cycle, the close wins. `done` rises with `count_us` = 0.
- R7: Once `done` is 1, input edges and ticks are ignored. `count_us`, `done` and `overflow` hold until the next `arm`.
- R8: If a tick arrives while the gate is open and `count_us` already equals MAX_US (default 1,000,000), then `overflow` and `done` rise and `count_us` stays at MAX_US. `count_us` never exceeds MAX_US.
- R9: Only clock edges with `tick` high increment the count while the gate is open.
- R10: `mode` = 2'b11 behaves as two-channel mode (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm | input | 1 | One-cycle pulse that clears the result and readies a measurement |
| mode | input | 2 | Interval definition: 00/11 two-channel, 01 pulse width, 10 period |
| start_in | input | 1 | Start channel (synchronous digital level) |
| stop_in | input | 1 | Stop channel (synchronous digital level) |
| tick | input | 1 | Reference tick enable, one cycle high per microsecond |
| count_us | output | $clog2(MAX_US+1) | Measured interval in ticks |
| done | output | 1 | Measurement complete |
| overflow | output | 1 | Interval exceeded MAX_US |

## Verification
A control state that is stuck, or that skips a state, shows up at the ports within a single cycle. It appears either as a `done` rising on the wrong edge or as a count that moves when it should be frozen. A wrong edge selection for a mode changes the final count by at least one tick, and that difference is visible at the edge where `done` rises. Counter faults near the limit show up as a count above MAX_US, or as `overflow` without `done`, in the cycle of the offending tick.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic [1:0] {
    MODE_AB     = 2'b00,
    MODE_PULSE  = 2'b01,
    MODE_PERIOD = 2'b10,
    MODE_AB_ALT = 2'b11
  } itmr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_OPEN  = 2'b10,
    ST_DONE  = 2'b11
  } itmr_state_e;
endpackage

// File: rtl/itmr_edge.sv
module itmr_edge #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] lvl,
  output logic [NCH-1:0] rise,
  output logic [NCH-1:0] fall
);
  logic [NCH-1:0] prev_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q[g];
    assign fall[g] = ~lvl[g] & prev_q[g];
  end
endmodule

// File: rtl/itmr_event_sel.sv
module itmr_event_sel
  import itmr_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] rise,      // [0] start channel, [1] stop channel
  input  logic [1:0] fall,
  input  logic       gate_open,
  output logic       set_ev,
  output logic       clr_ev
);
  always_comb begin
    set_ev = 1'b0;
    clr_ev = 1'b0;
    unique case (itmr_mode_e'(mode))
      MODE_PULSE: begin
        set_ev = rise[0];
        clr_ev = fall[0];
      end
      MODE_PERIOD: begin
        // toggle: the same edge polarity opens when closed, closes when open
        set_ev = rise[0] & ~gate_open;
        clr_ev = rise[0] &  gate_open;
      end
      default: begin
        set_ev = rise[0];
        clr_ev = rise[1];
      end
    endcase
  end
endmodule

// File: rtl/itmr_gate.sv
module itmr_gate
  import itmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic ovf_hit,
  output logic gate_open,
  output logic done
);
  itmr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (arm) begin
      st_d = ST_ARMED;
    end else begin
      unique case (st_q)
        ST_ARMED: begin
          if (set_ev && clr_ev) st_d = ST_DONE;   // reset dominates
          else if (set_ev)      st_d = ST_OPEN;
        end
        ST_OPEN: begin
          if (clr_ev || ovf_hit) st_d = ST_DONE;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign gate_open = (st_q == ST_OPEN);
  assign done      = (st_q == ST_DONE);
endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
  parameter int MAX_US = 1_000_000,
  parameter int CW     = $clog2(MAX_US + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cnt_en,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          ovf_hit
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_US);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          at_limit, reg_en;

  assign at_limit = (cnt_q == LIMIT);
  assign ovf_hit  = cnt_en & at_limit;
  assign reg_en   = clear | cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clear) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (cnt_en) begin
      if (at_limit) ovf_d = 1'b1;
      else          cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (reg_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int MAX_US = 1_000_000,
  parameter int CW     = $clog2(MAX_US + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [1:0]    mode,
  input  logic          start_in,
  input  logic          stop_in,
  input  logic          tick,
  output logic [CW-1:0] count_us,
  output logic          done,
  output logic          overflow
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [1:0] rise, fall;
  logic       set_ev, clr_ev, gate_open, ovf_hit;

  itmr_edge #(.NCH(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_core_n),
    .lvl  ({stop_in, start_in}),
    .rise (rise),
    .fall (fall)
  );

  itmr_event_sel u_sel (
    .mode     (mode),
    .rise     (rise),
    .fall     (fall),
    .gate_open(gate_open),
    .set_ev   (set_ev),
    .clr_ev   (clr_ev)
  );

  itmr_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .arm      (arm),
    .set_ev   (set_ev),
    .clr_ev   (clr_ev),
    .ovf_hit  (ovf_hit),
    .gate_open(gate_open),
    .done     (done)
  );

  itmr_count #(.MAX_US(MAX_US), .CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clear  (arm),
    .cnt_en (gate_open & tick),
    .count  (count_us),
    .ovf    (overflow),
    .ovf_hit(ovf_hit)
  );
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int MAX_US = 1_000_000,
  parameter int CW     = $clog2(MAX_US + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic [CW-1:0] count_us,
  input logic          done,
  input logic          overflow
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_US);

  p_arm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (count_us == '0) && !done && !overflow);

  p_count_rises_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> count_us >= $past(count_us));

  p_result_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done && $stable(count_us) && $stable(overflow));

  p_overflow_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> done);

  p_count_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count_us <= LIMIT);
endmodule

bind interval_timer itmr_checker #(.MAX_US(MAX_US), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .arm     (arm),
  .count_us(count_us),
  .done    (done),
  .overflow(overflow)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_US     = 12;
  localparam int CW         = $clog2(MAX_US + 1);

  logic          clk = 1'b0;
  logic          rst_n, arm, start_in, stop_in, tick;
  logic [1:0]    mode;
  logic [CW-1:0] count_us;
  logic          done, overflow;
  int            n_checks = 0;
  int            n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer #(.MAX_US(MAX_US)) dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode),
    .start_in(start_in), .stop_in(stop_in), .tick(tick),
    .count_us(count_us), .done(done), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_arm(input logic [1:0] m);
    mode = m; start_in = 0; stop_in = 0; tick = 0;
    @(negedge clk);
    arm = 1;
    @(negedge clk);
    arm = 0;
  endtask

  // Opens the gate, then closes it at loop step n per the mode's rule.
  task automatic measure(input logic [1:0] m, input int n, input int tdiv,
                         input string req);
    int exp = 0;
    do_arm(m);
    start_in = 1; tick = 1;            // start edge: its tick is not counted
    @(negedge clk);
    for (int i = 1; i <= n; i++) begin
      tick = (i % tdiv == 0);
      if (tick) exp++;
      if (m == 2'b10 && i == 2) start_in = 0;   // falling edge ignored in period mode
      if (m == 2'b01 || m == 2'b10) stop_in = ~stop_in;  // noise on unused channel
      if (i == n) begin
        case (m)
          2'b01:   start_in = 0;
          2'b10:   start_in = 1;
          default: stop_in  = 1;
        endcase
      end
      @(negedge clk);
    end
    tick = 0;
    check({req, " done"}, done, 1);
    check({req, " count"}, count_us, exp);
    check({req, " no overflow"}, overflow, 0);
  endtask

  task automatic t_reset;
    check("R1 count", count_us, 0);
    check("R1 done", done, 0);
    check("R1 overflow", overflow, 0);
  endtask

  task automatic t_armed_wait;
    do_arm(2'b00);
    tick = 1;
    repeat (5) @(negedge clk);
    tick = 0;
    check("R2 no count before start", count_us, 0);
    check("R2 not done", done, 0);
  endtask

  task automatic t_simultaneous;
    do_arm(2'b00);
    start_in = 1; stop_in = 1; tick = 1;
    @(negedge clk);
    check("R6 done", done, 1);
    check("R6 zero count", count_us, 0);
    repeat (3) @(negedge clk);
    tick = 0;
    check("R6 still zero", count_us, 0);
  endtask

  task automatic t_ignore_after_done;
    measure(2'b00, 5, 1, "R7 setup");
    start_in = 0; stop_in = 0; tick = 1;
    for (int i = 0; i < 8; i++) begin
      start_in = ~start_in;
      if (i % 2 == 0) stop_in = ~stop_in;
      @(negedge clk);
    end
    tick = 0;
    check("R7 count held", count_us, 5);
    check("R7 done held", done, 1);
    check("R7 overflow held", overflow, 0);
  endtask

  task automatic t_overflow;
    measure(2'b00, MAX_US, 1, "R8 at limit");
    do_arm(2'b00);
    start_in = 1; tick = 1;
    @(negedge clk);
    repeat (MAX_US + 6) @(negedge clk);
    tick = 0;
    check("R8 overflow", overflow, 1);
    check("R8 done", done, 1);
    check("R8 count saturated", count_us, MAX_US);
  endtask

  initial begin
    rst_n = 0; arm = 0; mode = 2'b00; start_in = 0; stop_in = 0; tick = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_armed_wait();
    measure(2'b00, 7, 1, "R3");
    measure(2'b00, 9, 3, "R9");
    measure(2'b01, 6, 1, "R4");
    measure(2'b10, 8, 1, "R5");
    measure(2'b10, 10, 2, "R5 gated");
    measure(2'b11, 4, 1, "R10");
    t_simultaneous();
    t_ignore_after_done();
    t_overflow();
    // re-arm after overflow clears everything
    do_arm(2'b00);
    check("R2 rearm count", count_us, 0);
    check("R2 rearm overflow", overflow, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule